// File: doc/BRIEF.md
# Remote DMA Data Port

This block is the host-facing data window into a network controller's local buffer memory. Host software loads a 16-bit transfer address and a 16-bit byte count, one byte at a time. It then reads or writes a single data port over and over. Each access touches the buffer memory at the current address, then moves the address forward and lowers the count by the size of the transfer. When an access uses up the count, the block emits a one-cycle completion pulse for the interrupt logic.

The transfer is 1, 2 or 4 bytes wide. A doubleword port access always moves four bytes. Otherwise a configuration input chooses between byte and word transfers. The address runs inside a receive ring: when it lands exactly on the ring stop address, it jumps back to the ring start. Only two windows of the memory respond, the low address-PROM area and the packet memory window. Outside them, writes never reach the memory and reads return all ones. Writes are refused outright while the count is zero. Reads are not refused.

The memory port is combinational on the host side. Address, byte lanes and write data are presented in the same cycle as the host access, and read data comes back in that cycle as well.

Top module: `rdma_port`

## Requirements
- R1: After reset the current address is 0, the remaining count is 0 and `done_pulse` is low.
- R2: A register write with `reg_sel` = 0 loads address bits [7:0], 1 loads address bits [15:8], 2 loads count bits [7:0] and 3 loads count bits [15:8]. The other half of the same register keeps its value.
- R3: The transfer length is 4 when `host_dword` is 1. Otherwise it is 2 when `wide_mode` is 1, and 1 when `wide_mode` is 0. Every performed access advances the address by that length, modulo 2^16.
- R4: If the advanced address equals `ring_stop`, the address becomes `ring_start` instead.
- R5: On a performed access, a count less than or equal to the length becomes 0, and `done_pulse` is high for exactly the following cycle. A larger count is reduced by the length and leaves `done_pulse` low.
- R6: A data-port write while the count is 0 has no effect. No memory write is issued, address and count stay unchanged, and no done pulse follows.
- R7: A data-port read while the count is 0 is still performed. Memory is read, the address advances, the count stays 0 and a done pulse follows.
- R8: An access lies inside the valid windows if its aligned address is below 32, or if the aligned address is at least `PMEM_LO` and the whole access ends at or below `PMEM_HI`. Outside the windows, reads return 0xFF, 0xFFFF or 0xFFFFFFFF according to length, `mem_we` and `mem_re` stay low, and address and count still update.
- R9: For 2- and 4-byte accesses, address bit 0 is cleared on `mem_addr`. Data is little-endian: byte lane i of `host_wdata`/`host_rdata` maps to memory address `mem_addr`+i. `mem_be` has its low length bits set, and unused upper read lanes are 0.
- R10: `mem_addr`, `mem_we`, `mem_re`, `mem_be` and `host_rdata` are valid in the same cycle as `host_req`. `mem_rdata` is taken to hold the bytes at `mem_addr`..`mem_addr`+3 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1 selects word transfers for non-doubleword accesses |
| ring_start | input | 16 | Ring start byte address (wrap target) |
| ring_stop | input | 16 | Ring stop byte address (wrap trigger) |
| reg_we | input | 1 | Register byte write strobe |
| reg_sel | input | 2 | Selects address low/high or count low/high |
| reg_wdata | input | 8 | Register byte value |
| host_req | input | 1 | Data-port access this cycle |
| host_wr | input | 1 | 1 for a data-port write, 0 for a read |
| host_dword | input | 1 | 1 for a 32-bit data-port access |
| host_wdata | input | 32 | Write data, little-endian lanes |
| host_rdata | output | 32 | Read data, little-endian lanes |
| mem_addr | output | 16 | Aligned byte address to buffer memory |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_be | output | 4 | Byte lanes of the access |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data at `mem_addr` |
| cur_addr | output | 16 | Current transfer address |
| cur_count | output | 16 | Remaining byte count |
| done_pulse | output | 1 | One-cycle transfer-complete pulse |

## Verification
The assertions assume that a register write and a data-port access never share a cycle, and that `ring_start` and `ring_stop` hold steady around an access. The stimulus applies register loads and data-port accesses in separate cycles, and it changes the ring bounds only in idle cycles. The stimulus also keeps `ring_start` below `ring_stop` inside the packet window, so the wrap check is never defeated by equal bounds.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_CNT_LO  = 2'd2,
    SEL_CNT_HI  = 2'd3
  } rdma_sel_e;

  // transfer length in bytes
  function automatic logic [2:0] xfer_len(input logic dword, input logic wide);
    if (dword) return 3'd4;
    else if (wide) return 3'd2;
    else return 3'd1;
  endfunction
endpackage

// File: rtl/rdma_window.sv
module rdma_window #(
  parameter int AW       = 16,
  parameter int PROM_TOP = 32,
  parameter int PMEM_LO  = 16'h4000,
  parameter int PMEM_HI  = 16'h8000
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    len,
  output logic [AW-1:0] eff_addr,
  output logic          hit,
  output logic [3:0]    lane_en
);
  logic [AW:0] end_x;
  logic        in_prom;
  logic        in_pmem;

  assign eff_addr = (len == 3'd1) ? addr : {addr[AW-1:1], 1'b0};
  assign end_x    = {1'b0, eff_addr} + (AW+1)'(len);
  assign in_prom  = ({1'b0, eff_addr} < (AW+1)'(PROM_TOP));
  assign in_pmem  = ({1'b0, eff_addr} >= (AW+1)'(PMEM_LO)) && (end_x <= (AW+1)'(PMEM_HI));
  assign hit      = in_prom || in_pmem;

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign lane_en[i] = (3'(i) < len);
  end
endmodule

// File: rtl/rdma_lanes.sv
module rdma_lanes (
  input  logic        hit,
  input  logic [3:0]  lane_en,
  input  logic [31:0] mem_rdata,
  output logic [31:0] rdata
);
  for (genvar i = 0; i < 4; i++) begin : g_rd
    assign rdata[8*i +: 8] = !lane_en[i] ? 8'h00 :
                             (hit ? mem_rdata[8*i +: 8] : 8'hFF);
  end
endmodule

// File: rtl/rdma_ptr.sv
module rdma_ptr
  import rdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          step,
  input  logic [2:0]    len,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_stop,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] count_q,
  output logic          done_q
);
  function automatic logic [AW-1:0] advance(input logic [AW-1:0] a, input logic [2:0] l,
                                            input logic [AW-1:0] s0, input logic [AW-1:0] s1);
    logic [AW-1:0] n;
    n = a + AW'(l);
    return (n == s1) ? s0 : n;
  endfunction

  function automatic logic [CW-1:0] consume(input logic [CW-1:0] c, input logic [2:0] l);
    return (c <= CW'(l)) ? '0 : c - CW'(l);
  endfunction

  wire       exhaust = (count_q <= CW'(len));
  rdma_sel_e sel;
  assign sel = rdma_sel_e'(reg_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (reg_we) begin
        case (sel)
          SEL_ADDR_LO: addr_q[7:0]     <= reg_wdata;
          SEL_ADDR_HI: addr_q[AW-1:8]  <= reg_wdata[AW-9:0];
          SEL_CNT_LO:  count_q[7:0]    <= reg_wdata;
          default:     count_q[CW-1:8] <= reg_wdata[CW-9:0];
        endcase
      end else if (step) begin
        addr_q  <= advance(addr_q, len, ring_start, ring_stop);
        count_q <= consume(count_q, len);
        done_q  <= exhaust;
      end
    end
  end

  assert_done_at_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> count_q == '0);
  assert_count_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reg_we && count_q != '0) |=> count_q < $past(count_q));
  assert_never_parks_on_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !reg_we && ring_start != ring_stop) |=> addr_q != $past(ring_stop));
  assert_half_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == 2'd0) |=> addr_q[AW-1:8] == $past(addr_q[AW-1:8]));
endmodule

// File: rtl/rdma_port.sv
module rdma_port
  import rdma_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter int PROM_TOP = 32,
  parameter int PMEM_LO  = 16'h4000,
  parameter int PMEM_HI  = 16'h8000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wide_mode,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_stop,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [7:0]    reg_wdata,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic          host_dword,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [3:0]    mem_be,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count,
  output logic          done_pulse
);
  logic [2:0]    len;
  logic          win_hit;
  logic [3:0]    lanes;
  logic          step;
  logic          wr_blocked;

  assign len        = xfer_len(host_dword, wide_mode);
  assign wr_blocked = host_wr && (cur_count == '0);
  assign step       = host_req && !reg_we && !wr_blocked;

  rdma_window #(.AW(AW), .PROM_TOP(PROM_TOP), .PMEM_LO(PMEM_LO), .PMEM_HI(PMEM_HI)) u_window (
    .addr(cur_addr), .len(len), .eff_addr(mem_addr), .hit(win_hit), .lane_en(lanes)
  );

  rdma_lanes u_lanes (
    .hit(win_hit), .lane_en(lanes), .mem_rdata(mem_rdata), .rdata(host_rdata)
  );

  rdma_ptr #(.AW(AW), .CW(CW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .step(step), .len(len), .ring_start(ring_start), .ring_stop(ring_stop),
    .addr_q(cur_addr), .count_q(cur_count), .done_q(done_pulse)
  );

  assign mem_we    = step && host_wr && win_hit;
  assign mem_re    = step && !host_wr && win_hit;
  assign mem_be    = lanes;
  assign mem_wdata = host_wdata;

  assert_blocked_write_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_wr && !reg_we && cur_count == '0) |=>
      ($stable(cur_addr) && $stable(cur_count) && !done_pulse));
  assert_oob_byte_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_wr && !host_dword && !wide_mode && !win_hit) |-> host_rdata == 32'h0000_00FF);
  assert_write_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((mem_addr < AW'(PROM_TOP)) || (mem_addr >= AW'(PMEM_LO))));
  assert_wide_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && (host_dword || wide_mode)) |-> mem_addr[0] == 1'b0);
endmodule

// File: tb/rdma_port_tb.sv
`timescale 1ns/1ps
module rdma_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic [15:0] ring_start = 16'h0200, ring_stop = 16'h0400;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic        host_req = 1'b0, host_wr = 1'b0, host_dword = 1'b0;
  logic [31:0] host_wdata = 32'h0;
  logic [31:0] host_rdata, mem_wdata, mem_rdata;
  logic [15:0] mem_addr, cur_addr, cur_count;
  logic        mem_we, mem_re, done_pulse;
  logic [3:0]  mem_be;

  int vectors = 0, miscompares = 0;
  bit finished = 0;
  int m_addr = 0, m_cnt = 0;
  bit m_done = 0;
  logic [7:0] bmem [0:1023];

  always #2.5 clk = ~clk;

  rdma_port #(.PMEM_LO(16'h0200), .PMEM_HI(16'h0400)) u_dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .ring_start(ring_start), .ring_stop(ring_stop),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .host_req(host_req),
    .host_wr(host_wr), .host_dword(host_dword), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cur_addr(cur_addr), .cur_count(cur_count), .done_pulse(done_pulse)
  );

  assign mem_rdata = {bmem[10'(mem_addr + 16'd3)], bmem[10'(mem_addr + 16'd2)],
                      bmem[10'(mem_addr + 16'd1)], bmem[10'(mem_addr)]};

  always @(posedge clk) begin
    if (mem_we) begin
      for (int i = 0; i < 4; i++)
        if (mem_be[i]) bmem[10'(mem_addr + 16'(i))] <= mem_wdata[8*i +: 8];
    end
  end

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic chk_state(input string rq);
    chk(rq, "cur_addr", cur_addr, m_addr);
    chk(rq, "cur_count", cur_count, m_cnt);
    chk(rq, "done_pulse", done_pulse, m_done);
  endtask

  task automatic regw(input int sel, input int val, input string rq);
    reg_we = 1'b1; reg_sel = 2'(sel); reg_wdata = 8'(val);
    #1 chk_state(rq);
    case (sel)
      0: m_addr = (m_addr & 'hFF00) | val;
      1: m_addr = (m_addr & 'h00FF) | (val << 8);
      2: m_cnt  = (m_cnt & 'hFF00) | val;
      default: m_cnt = (m_cnt & 'h00FF) | (val << 8);
    endcase
    m_done = 0;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_ptr(input int a, input int c);
    regw(0, a & 'hFF, "R2"); regw(1, a >> 8, "R2");
    regw(2, c & 'hFF, "R2"); regw(3, c >> 8, "R2");
  endtask

  task automatic idle(input string rq);
    #1 chk_state(rq);
    m_done = 0;
    @(negedge clk);
  endtask

  task automatic access(input bit wr, input bit dw, input logic [31:0] wd, input string rq);
    int len, eff, nxt;
    bit win, go;
    logic [31:0] exp_rd;
    len = dw ? 4 : (wide_mode ? 2 : 1);
    eff = (len == 1) ? m_addr : (m_addr & 'hFFFE);
    win = (eff < 32) || (eff >= 'h200 && eff + len <= 'h400);
    go  = !wr || (m_cnt != 0);
    exp_rd = 32'h0;
    for (int i = 0; i < len; i++)
      exp_rd[8*i +: 8] = win ? bmem[(eff + i) % 1024] : 8'hFF;
    host_req = 1'b1; host_wr = wr; host_dword = dw; host_wdata = wd;
    #1 chk_state(rq);
    chk(rq, "mem_we", mem_we, go && wr && win);
    chk(rq, "mem_re", mem_re, !wr && win);
    if (!wr) chk(rq, "host_rdata", host_rdata, exp_rd);
    if (go && win) begin
      chk(rq, "mem_addr", mem_addr, eff);
      chk(rq, "mem_be", mem_be, (1 << len) - 1);
    end
    if (go) begin
      nxt = (m_addr + len) & 'hFFFF;
      if (nxt == ring_stop) nxt = ring_start;
      m_done = (m_cnt <= len);
      m_cnt  = m_done ? 0 : m_cnt - len;
      m_addr = nxt;
    end else m_done = 0;
    @(negedge clk);
    host_req = 1'b0; host_wr = 1'b0; host_dword = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
    repeat (3) @(negedge clk);
    idle("R1");                         // reset state R1
    rst_n = 1'b1;
    // R2 R3 R9: byte writes then a dword write that exhausts the count (R5)
    set_ptr('h0200, 8);
    access(1, 0, 32'h0000_00A1, "R3");
    access(1, 0, 32'h0000_00A2, "R9");
    access(1, 0, 32'h0000_00A3, "R3");
    access(1, 0, 32'h0000_00A4, "R9");
    access(1, 1, 32'h4433_2211, "R5");
    idle("R5");
    idle("R5");
    // R2: low-half load keeps the high half
    regw(0, 'h00, "R2");
    regw(2, 'h08, "R2");
    regw(3, 'h00, "R2");
    access(0, 0, 0, "R9");
    access(0, 0, 0, "R9");
    access(0, 0, 0, "R3");
    access(0, 0, 0, "R3");
    wide_mode = 1'b1;
    access(0, 0, 0, "R9");
    access(0, 1, 0, "R5");
    idle("R5");
    // R6: write at zero count is refused
    access(1, 0, 32'hDEAD_BEEF, "R6");
    idle("R6");
    // R7: read at zero count still runs
    access(0, 0, 0, "R7");
    idle("R7");
    // R4: wrap at ring stop
    ring_stop = 16'h0208;
    set_ptr('h0204, 6);
    access(1, 0, 32'h0000_BEEF, "R4");
    access(1, 0, 32'h0000_CAFE, "R4");
    access(1, 0, 32'h0000_F00D, "R4");
    idle("R4");
    ring_stop = 16'h0400;
    set_ptr('h0200, 6);
    access(0, 0, 0, "R4");
    access(0, 0, 0, "R10");
    // R9: odd address word read is aligned
    set_ptr('h0203, 2);
    access(0, 0, 0, "R9");
    // R8: outside both windows
    set_ptr('h0100, 'h10);
    wide_mode = 1'b0;
    access(0, 0, 0, "R8");
    wide_mode = 1'b1;
    access(0, 0, 0, "R8");
    access(0, 1, 0, "R8");
    access(1, 1, 32'h1234_5678, "R8");
    set_ptr('h03FE, 8);
    access(0, 1, 0, "R8");
    set_ptr('h03FE, 8);
    access(0, 0, 0, "R8");
    // R8 R10: address PROM area
    set_ptr('h001E, 4);
    access(1, 0, 32'h0000_5A5B, "R10");
    set_ptr('h001E, 4);
    access(0, 0, 0, "R8");
    idle("R10");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule